// File: doc/BRIEF.md
# NAND Hamming ECC Accumulator

This block sits beside a NAND Flash data bus and folds every data byte that passes into a Hamming parity code. Software sets the enable bit, moves one block of data (256 to 8192 bytes, chosen by a 3-bit page-size field) and then reads the 32-bit code. It compares the stored code with a freshly computed one. A single flipped bit anywhere in the block changes exactly one bit of every parity pair, and the changed bits spell out the byte index and the bit index of the error. A double-bit error leaves at least one pair with both or neither bit changed.

A byte counts only when the bank select is active, a read or write strobe is high, and the cycle is marked as neither command nor address. Each clock cycle that meets this condition supplies one byte. An internal byte index selects which line-parity half each byte updates. When the chosen length is reached, the code freezes and the done flag rises. Clearing the enable bit zeroes the code, the index and the flag.

Top module: `nand_ecc_acc`

## Requirements
- R1: Code bits [5:0] hold column parity. For k in 0..2, bit 2k+1 is the XOR of all data bits whose bit position has bit k set, and bit 2k is the XOR of those with bit k clear, taken over every accepted byte.
- R2: For line j, bit 7+2j is the XOR of the row parities (XOR of the 8 data bits) of accepted bytes whose byte index has bit j set. Bit 6+2j is the same over bytes whose index bit j is clear. The first accepted byte after enable has index 0.
- R3: page_sel values 0..5 select 256 << page_sel bytes, and values 6 and 7 select 8192. Only lines j < log2(length) are used, and all code bits above them read zero.
- R4: A byte is accepted in a cycle where bank_sel is 1, rd_stb or wr_stb is 1, and both cmd_cycle and addr_cycle are 0. Read and write strobes are treated alike. Cycles with no strobe or with bank_sel low change nothing.
- R5: Cycles with cmd_cycle or addr_cycle high leave the code and the byte index unchanged.
- R6: No byte is accepted while ecc_en is 0.
- R7: A cycle with ecc_en low sets ecc_code to 0 and ecc_done to 0 at the next clock edge. Re-enabling starts a new block at index 0.
- R8: ecc_done rises at the edge that accepts the last byte of the block and not earlier. After that, further data strobes do not change the code.
- R9: For two blocks that differ in one bit, every one of the 3 + log2(length) parity pairs differs in exactly one bit. The odd bits of the line pairs give the byte index, and the odd bits of the column pairs give the bit position.
- R10: After reset, ecc_code is 0 and ecc_done is 0.
- R11: The code reflects an accepted byte at the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Accumulate while 1; clear while 0 |
| page_sel | input | 3 | Block length select |
| bank_sel | input | 1 | Bank chip select, active high |
| rd_stb | input | 1 | Read data strobe |
| wr_stb | input | 1 | Write data strobe |
| cmd_cycle | input | 1 | Current cycle carries a command |
| addr_cycle | input | 1 | Current cycle carries an address |
| bus_data | input | 8 | NAND data bus byte |
| ecc_code | output | 32 | Accumulated parity code |
| ecc_done | output | 1 | Block length reached |

## Verification
Pseudo-random blocks at several page sizes are compared with an independent parity model. Some blocks are driven by read strobes and some by write strobes, and some are interleaved with command, address and deselected cycles, so a wrongly qualified byte shows up as a code mismatch. Short and overlong transfers separate an early or missing done flag from correct freezing. Blocks that differ in a single bit at chosen positions check that the syndrome decodes to exactly that byte and bit.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    localparam int DATA_W    = 8;
    localparam int COL_PAIRS = 3;
    localparam int MIN_LG    = 8;
    localparam int MAX_LG    = 13;
    localparam int SEL_W     = 3;
    localparam int LG_W      = 4;
    localparam int NUM_SIZES = MAX_LG - MIN_LG + 1;
    localparam int CNT_W     = MAX_LG + 1;
    localparam int COL_W     = 2 * COL_PAIRS;
    localparam int LINE_W    = 2 * MAX_LG;
    localparam int CODE_W    = COL_W + LINE_W;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_DATA = 2'd1,
        BUS_CMD  = 2'd2,
        BUS_ADDR = 2'd3
    } bus_kind_t;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [COL_W-1:0]  col;
    } ecc_code_t;

    function automatic logic [LG_W-1:0] sel_to_lg(input logic [SEL_W-1:0] sel);
        if (int'(sel) >= NUM_SIZES)
            return LG_W'(MAX_LG);
        return LG_W'(MIN_LG + int'(sel));
    endfunction

    function automatic logic [COL_W-1:0] col_parity(input logic [DATA_W-1:0] d);
        logic [COL_W-1:0] c;
        c = '0;
        for (int k = 0; k < COL_PAIRS; k++) begin
            for (int b = 0; b < DATA_W; b++) begin
                if (((b >> k) & 1) == 1)
                    c[2*k+1] = c[2*k+1] ^ d[b];
                else
                    c[2*k] = c[2*k] ^ d[b];
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/ecc_qualify.sv
module ecc_qualify
    import nand_ecc_pkg::*;
(
    input  logic      en,
    input  logic      done,
    input  logic      bank_sel,
    input  logic      rd_stb,
    input  logic      wr_stb,
    input  logic      cmd_cycle,
    input  logic      addr_cycle,
    output bus_kind_t kind,
    output logic      accept
);
    always_comb begin
        if (!bank_sel)
            kind = BUS_IDLE;
        else if (cmd_cycle)
            kind = BUS_CMD;
        else if (addr_cycle)
            kind = BUS_ADDR;
        else if (rd_stb || wr_stb)
            kind = BUS_DATA;
        else
            kind = BUS_IDLE;
    end

    assign accept = en && !done && (kind == BUS_DATA);
endmodule

// File: rtl/ecc_counter.sv
module ecc_counter
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              accept,
    input  logic [LG_W-1:0]   lg,
    output logic [MAX_LG-1:0] idx,
    output logic              done
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] block_len;
    logic [CNT_W-1:0] count_nxt;

    assign block_len = CNT_W'(1) << lg;
    assign count_nxt = count_q + CNT_W'(1);
    assign idx       = count_q[MAX_LG-1:0];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            count_q <= '0;
            done    <= 1'b0;
        end else if (accept) begin
            count_q <= count_nxt;
            if (count_nxt == block_len)
                done <= 1'b1;
        end
    end

    // R8: the index advances only on an accepted byte
    a_r8_idx_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !accept) |=> $stable(count_q));
endmodule

// File: rtl/ecc_parity.sv
module ecc_parity
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              accept,
    input  logic [DATA_W-1:0] data,
    input  logic [MAX_LG-1:0] idx,
    input  logic [LG_W-1:0]   lg,
    output ecc_code_t         code
);
    ecc_code_t code_q;
    ecc_code_t code_nxt;
    logic      row_par;

    assign row_par = ^data;

    always_comb begin
        code_nxt = code_q;
        if (accept) begin
            code_nxt.col = code_q.col ^ col_parity(data);
            for (int j = 0; j < MAX_LG; j++) begin
                if (j < int'(lg)) begin
                    if (idx[j])
                        code_nxt.line[2*j+1] = code_q.line[2*j+1] ^ row_par;
                    else
                        code_nxt.line[2*j] = code_q.line[2*j] ^ row_par;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            code_q <= '0;
        else
            code_q <= code_nxt;
    end

    assign code = code_q;
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  logic [SEL_W-1:0]  page_sel,
    input  logic              bank_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              cmd_cycle,
    input  logic              addr_cycle,
    input  logic [DATA_W-1:0] bus_data,
    output logic [CODE_W-1:0] ecc_code,
    output logic              ecc_done
);
    bus_kind_t         kind;
    logic              accept;
    logic [LG_W-1:0]   lg;
    logic [MAX_LG-1:0] idx;
    ecc_code_t         code;

    assign lg = sel_to_lg(page_sel);

    ecc_qualify u_qual (
        .en         (ecc_en),
        .done       (ecc_done),
        .bank_sel   (bank_sel),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .cmd_cycle  (cmd_cycle),
        .addr_cycle (addr_cycle),
        .kind       (kind),
        .accept     (accept)
    );

    ecc_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (ecc_en),
        .accept (accept),
        .lg     (lg),
        .idx    (idx),
        .done   (ecc_done)
    );

    ecc_parity u_par (
        .clk    (clk),
        .rst    (rst),
        .en     (ecc_en),
        .accept (accept),
        .data   (bus_data),
        .idx    (idx),
        .lg     (lg),
        .code   (code)
    );

    assign ecc_code = code;

    // R5: command and address cycles leave the code alone
    a_r5_cmd_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        (ecc_en && (cmd_cycle || addr_cycle)) |=> $stable(ecc_code));

    // R4: no strobe or no bank select means no change
    a_r4_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (ecc_en && (!bank_sel || (!rd_stb && !wr_stb))) |=> $stable(ecc_code));

    // R7: a disabled cycle clears the result and the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        !ecc_en |=> (ecc_code == '0) && !ecc_done);

    // R8: a finished block stays frozen while enabled
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (ecc_en && ecc_done) |=> $stable(ecc_code) && ecc_done);

    // R11: an accepted byte with odd row parity moves the code
    a_r11_update: assert property (@(posedge clk) disable iff (rst)
        (accept && (^bus_data)) |=> !$stable(ecc_code));
endmodule

// File: tb/tb_nand_ecc_acc.sv
module tb_nand_ecc_acc;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 6;
    // row: {page_sel[2:0], seed[7:0], use_rd, noise}
    localparam logic [12:0] ROWS [NROWS] = '{
        {3'd0, 8'h3C, 1'b0, 1'b1},
        {3'd1, 8'hA5, 1'b1, 1'b1},
        {3'd2, 8'h17, 1'b0, 1'b0},
        {3'd5, 8'hE2, 1'b1, 1'b1},
        {3'd7, 8'h5B, 1'b0, 1'b1},
        {3'd0, 8'hFF, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ecc_en = 1'b0;
    logic [2:0]  page_sel = 3'd0;
    logic        bank_sel = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic        cmd_cycle = 1'b0;
    logic        addr_cycle = 1'b0;
    logic [7:0]  bus_data = 8'h00;
    logic [31:0] ecc_code;
    logic        ecc_done;

    int tests = 0;
    int fails = 0;
    logic [7:0] mem [8192];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc_acc dut (
        .clk(clk), .rst(rst), .ecc_en(ecc_en), .page_sel(page_sel),
        .bank_sel(bank_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .cmd_cycle(cmd_cycle), .addr_cycle(addr_cycle), .bus_data(bus_data),
        .ecc_code(ecc_code), .ecc_done(ecc_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int len_of(input int sel);
        return (sel > 5) ? 8192 : (256 << sel);
    endfunction

    function automatic int lg_of(input int sel);
        return (sel > 5) ? 13 : 8 + sel;
    endfunction

    function automatic logic [31:0] model(input int n, input int lg);
        logic [31:0] c = '0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = mem[i];
            for (int b = 0; b < 8; b++)
                for (int k = 0; k < 3; k++)
                    if (((b >> k) & 1) == 1) c[2*k+1] ^= d[b];
                    else c[2*k] ^= d[b];
            for (int j = 0; j < lg; j++)
                if (((i >> j) & 1) == 1) c[7+2*j] ^= ^d;
                else c[6+2*j] ^= ^d;
        end
        return c;
    endfunction

    task automatic idle_bus();
        bank_sel = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
        cmd_cycle = 1'b0; addr_cycle = 1'b0; bus_data = 8'h00;
    endtask

    task automatic fill(input int seed, input int fidx, input int fbit);
        for (int i = 0; i < 8192; i++)
            mem[i] = 8'((i * 37 + seed * 11) ^ (i >> 5) ^ seed);
        if (fidx >= 0) mem[fidx][fbit] = ~mem[fidx][fbit];
    endtask

    // clears, re-enables, then drives nbytes data strobes
    task automatic run_block(input int sel, input bit use_rd, input bit noise, input int nbytes);
        @(negedge clk);
        idle_bus(); ecc_en = 1'b0;
        @(negedge clk);
        ecc_en = 1'b1; page_sel = 3'(sel);
        for (int i = 0; i < nbytes; i++) begin
            if (noise && (i % 7) == 3) begin
                bus_data = ~mem[i % 8192];
                case ((i / 7) % 3)
                    0: begin bank_sel = 1; wr_stb = 1; cmd_cycle = 1; end
                    1: begin bank_sel = 1; wr_stb = 1; addr_cycle = 1; end
                    default: begin bank_sel = 0; rd_stb = 1; end
                endcase
                @(negedge clk);
                idle_bus();
            end
            bank_sel = 1'b1; rd_stb = use_rd; wr_stb = !use_rd;
            bus_data = mem[i % 8192];
            @(negedge clk);
            idle_bus();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] a_code, s;
        int pairs_ok, byte_idx, bit_idx;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 code", ecc_code, 32'h0);
        chk("R10 done", {31'b0, ecc_done}, 32'h0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5: table of random blocks vs model
        for (int r = 0; r < NROWS; r++) begin
            int sel = int'(ROWS[r][12:10]);
            fill(int'(ROWS[r][9:2]), -1, 0);
            run_block(sel, ROWS[r][1], ROWS[r][0], len_of(sel));
            chk("R1 R2 R3 R4 R5 block code", ecc_code, model(len_of(sel), lg_of(sel)));
            chk("R8 done at length", {31'b0, ecc_done}, 32'h1);
        end

        // R3: 256-byte block leaves bits [31:22] zero
        fill(8'h91, -1, 0);
        run_block(0, 0, 0, 256);
        chk("R3 upper bits zero", {22'b0, ecc_code[31:22]}, 32'h0);

        // R8: one short of length is not done, overlong is frozen
        run_block(0, 1, 0, 255);
        chk("R8 not done early", {31'b0, ecc_done}, 32'h0);
        chk("R8 partial code", ecc_code, model(255, 8));
        run_block(0, 0, 0, 261);
        chk("R8 frozen code", ecc_code, model(256, 8));
        chk("R8 done held", {31'b0, ecc_done}, 32'h1);

        // R11: first byte visible right after its edge
        run_block(1, 0, 0, 1);
        chk("R11 one byte", ecc_code, model(1, 9));

        // R5: command and address cycles alone change nothing
        run_block(1, 0, 0, 3);
        a_code = ecc_code;
        bank_sel = 1; wr_stb = 1; cmd_cycle = 1; bus_data = 8'hFE;
        @(negedge clk);
        idle_bus(); bank_sel = 1; wr_stb = 1; addr_cycle = 1; bus_data = 8'h01;
        @(negedge clk);
        idle_bus();
        chk("R5 cmd addr ignored", ecc_code, a_code);
        // R4: deselected strobe and selected idle bus change nothing
        bank_sel = 0; rd_stb = 1; bus_data = 8'h01;
        @(negedge clk);
        idle_bus(); bank_sel = 1; bus_data = 8'h01;
        @(negedge clk);
        idle_bus();
        chk("R4 unqualified ignored", ecc_code, a_code);
        // R4: the next accepted byte still lands at index 3
        bank_sel = 1; rd_stb = 1; bus_data = mem[3];
        @(negedge clk);
        idle_bus();
        chk("R4 index kept", ecc_code, model(4, 9));

        // R7: disabling clears code and flag
        run_block(0, 0, 0, 256);
        ecc_en = 1'b0;
        @(negedge clk);
        chk("R7 code cleared", ecc_code, 32'h0);
        chk("R7 done cleared", {31'b0, ecc_done}, 32'h0);
        // R6: strobes while disabled are ignored
        bank_sel = 1; wr_stb = 1; bus_data = 8'h01;
        @(negedge clk);
        idle_bus();
        chk("R6 disabled ignored", ecc_code, 32'h0);

        // R9: single-bit flips decode to byte and bit
        for (int t = 0; t < 2; t++) begin
            int fi = (t == 0) ? 100 : 255;
            int fb = (t == 0) ? 5 : 0;
            fill(8'h6D, -1, 0);
            run_block(0, 0, 0, 256);
            a_code = ecc_code;
            fill(8'h6D, fi, fb);
            run_block(0, 1, 0, 256);
            s = a_code ^ ecc_code;
            pairs_ok = 0;
            for (int p = 0; p < 11; p++)
                if ((s[2*p] ^ s[2*p+1]) == 1'b1) pairs_ok++;
            bit_idx = {29'b0, s[5], s[3], s[1]};
            byte_idx = 0;
            for (int j = 0; j < 8; j++) byte_idx |= int'(s[7+2*j]) << j;
            chk("R9 pairs single", pairs_ok, 11);
            chk("R9 byte index", byte_idx, fi);
            chk("R9 bit index", bit_idx, fb);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule